// File: doc/BRIEF.md
# Flash Configuration Loader

After reset, this boot controller reads a configuration image out of a 1 MB serial flash and sends it to a volatile target over an 8-bit parallel bus, so the target is loaded again on every power-up. The controller first reads a fixed 24-byte header and checks it. The header holds a magic word, a 16-byte identity, and the length of the stream. If the header is valid, the controller streams exactly that many bytes from the image area. It sends one byte per single-cycle strobe.

After the last byte, the loader waits for the target to report done and to present a signature. A matching signature ends the run in a success state. A wrong signature, a missing reply within a timeout, or a bad header ends the run in an error state with a code that gives the cause. Both final states hold until the next reset.

Flash reads use SPI mode 0 with the plain read command. The controller shifts out the command and a 24-bit address MSB first, then reads data continuously.

Top module: `cfg_loader`

## Requirements
- R1: While reset is held, select is high, the serial clock is low, no strobe is issued, busy is 1, and ok and err are 0.
- R2: Each flash access is one select-low transaction: command byte 0x03, then a 24-bit address, MSB first. MOSI changes only while the serial clock falls, and MISO is sampled at its rise. The header is read as one 24-byte burst from 0x2A200.
- R3: Header bytes 0..3 form a little-endian word that must equal 0x11223344, so the flash holds 44 33 22 11. A mismatch ends in error with code 1 and no strobe. Code 1 takes precedence over code 2.
- R4: Header bytes 4..19 must equal the ID parameter, where byte k is compared with ID[8k+7:8k]. A mismatch ends in error with code 2 and no strobe.
- R5: Header bytes 20..23 form a little-endian length. A length of zero, or 0x2A400 + length > 0x100000, ends in error with code 3 before any strobe. A length that ends exactly at 0x100000 is accepted.
- R6: The stream is read in a second transaction from 0x2A400. Each byte, assembled MSB first, appears on cfg_data with a one-cycle strobe, in flash order. Exactly `length` strobes are issued, and select is high once the last strobe is seen.
- R7: After the stream, a tgt_done with tgt_sig equal to SIGNATURE (default 0xC0DE) ends in ok with err_code 0.
- R8: A tgt_done with any other tgt_sig ends in error with code 4.
- R9: If no tgt_done arrives, err rises with code 5 exactly SIG_TIMEOUT cycles after the last strobe.
- R10: Once ok or err is set, the state, the code and the select line hold, and no strobe occurs, whatever tgt_done does, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | output | 1 | Flash select, active low |
| spi_sclk | output | 1 | Serial clock, half the core rate |
| spi_mosi | output | 1 | Command and address to the flash |
| spi_miso | input | 1 | Data from the flash |
| cfg_data | output | 8 | Configuration byte to the target |
| cfg_strobe | output | 1 | One-cycle valid for cfg_data |
| tgt_done | input | 1 | Target reports configuration complete |
| tgt_sig | input | 16 | Signature from the target, read with tgt_done |
| busy | output | 1 | Load in progress |
| ok | output | 1 | Load finished and signature matched |
| err | output | 1 | Load failed |
| err_code | output | 3 | 0 none, 1 magic, 2 identity, 3 length, 4 signature, 5 timeout |

## Verification
The bench targets four kinds of corner case:
- **Length decoding and bounds.** It uses a length of 0x103, which is only legal when read little-endian, so a big-endian design would reject it as too long. It also uses a zero length, and lengths one byte beyond and exactly at the end of flash; an off-by-one bound check would flip either of the last two.
- **Header checks.** It corrupts only the last identity byte, which catches a check that stops early. It corrupts both magic and identity together, which exposes a wrong error precedence.
- **Timeout timing.** It measures the timeout to the exact cycle, which catches an off-by-one timer.
- **Stream and final states.** It compares every streamed byte and the strobe count against the flash pattern, which catches lost, duplicated or bit-swapped bytes. It then toggles done after the run ends to catch a final state that does not hold.

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter logic [23:0]  HDR_ADDR    = 24'h2A200,
  parameter logic [23:0]  STREAM_ADDR = 24'h2A400,
  parameter logic [32:0]  FLASH_BYTES = 33'h100000,
  parameter logic [31:0]  MAGIC       = 32'h11223344,
  parameter logic [127:0] ID          = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0,
  parameter logic [15:0]  SIGNATURE   = 16'hC0DE,
  parameter int           SIG_TIMEOUT = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        spi_cs_n,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic [7:0]  cfg_data,
  output logic        cfg_strobe,
  input  logic        tgt_done,
  input  logic [15:0] tgt_sig,
  output logic        busy,
  output logic        ok,
  output logic        err,
  output logic [2:0]  err_code
);

  localparam int TW = $clog2(SIG_TIMEOUT + 1);

  typedef enum logic [2:0] {S_START, S_HDR, S_CHECK, S_STREAM, S_WAIT, S_OK, S_ERR} state_t;

  state_t        st;
  logic [31:0]   tx;
  logic [5:0]    bitcnt;
  logic [6:0]    rx;
  logic [4:0]    hidx;
  logic [31:0]   len_r;
  logic [31:0]   remain;
  logic          magic_bad;
  logic          id_bad;
  logic [TW-1:0] timer;

  wire [7:0]  nb        = {rx, spi_miso};
  wire        shifting  = !spi_cs_n && (st == S_HDR || st == S_STREAM);
  wire        byte_done = shifting && !spi_sclk && bitcnt == 6'd39;
  wire [3:0]  idk       = 4'(hidx - 5'd4);
  wire [32:0] end_addr  = {9'd0, STREAM_ADDR} + {1'b0, len_r};
  wire        len_bad   = (len_r == 32'd0) || (end_addr > FLASH_BYTES);

  assign spi_mosi = tx[31];
  assign busy     = (st != S_OK) && (st != S_ERR);
  assign ok       = (st == S_OK);
  assign err      = (st == S_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_START;
      spi_cs_n   <= 1'b1;
      spi_sclk   <= 1'b0;
      tx         <= '0;
      bitcnt     <= '0;
      rx         <= '0;
      hidx       <= '0;
      len_r      <= '0;
      remain     <= '0;
      magic_bad  <= 1'b0;
      id_bad     <= 1'b0;
      timer      <= '0;
      cfg_data   <= '0;
      cfg_strobe <= 1'b0;
      err_code   <= '0;
    end else begin
      cfg_strobe <= 1'b0;
      if (shifting) begin
        spi_sclk <= ~spi_sclk;
        if (!spi_sclk) begin
          if (bitcnt < 6'd32) begin
            bitcnt <= bitcnt + 6'd1;
          end else begin
            rx     <= nb[6:0];
            bitcnt <= (bitcnt == 6'd39) ? 6'd32 : bitcnt + 6'd1;
          end
        end else begin
          tx <= {tx[30:0], 1'b0};
        end
      end
      case (st)
        S_START: begin
          spi_cs_n <= 1'b0;
          spi_sclk <= 1'b0;
          tx       <= {8'h03, HDR_ADDR};
          bitcnt   <= '0;
          hidx     <= '0;
          st       <= S_HDR;
        end
        S_HDR: if (byte_done) begin
          if (hidx < 5'd4) begin
            if (nb != MAGIC[{hidx[1:0], 3'b000} +: 8]) magic_bad <= 1'b1;
          end else if (hidx < 5'd20) begin
            if (nb != ID[{idk, 3'b000} +: 8]) id_bad <= 1'b1;
          end else begin
            len_r[{hidx[1:0], 3'b000} +: 8] <= nb;
          end
          hidx <= hidx + 5'd1;
          if (hidx == 5'd23) begin
            spi_cs_n <= 1'b1;
            spi_sclk <= 1'b0;
            st       <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (magic_bad) begin
            err_code <= 3'd1;
            st       <= S_ERR;
          end else if (id_bad) begin
            err_code <= 3'd2;
            st       <= S_ERR;
          end else if (len_bad) begin
            err_code <= 3'd3;
            st       <= S_ERR;
          end else begin
            spi_cs_n <= 1'b0;
            spi_sclk <= 1'b0;
            tx       <= {8'h03, STREAM_ADDR};
            bitcnt   <= '0;
            remain   <= len_r;
            st       <= S_STREAM;
          end
        end
        S_STREAM: if (byte_done) begin
          cfg_data   <= nb;
          cfg_strobe <= 1'b1;
          remain     <= remain - 32'd1;
          if (remain == 32'd1) begin
            spi_cs_n <= 1'b1;
            spi_sclk <= 1'b0;
            timer    <= '0;
            st       <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (tgt_done) begin
            if (tgt_sig == SIGNATURE) begin
              st <= S_OK;
            end else begin
              err_code <= 3'd4;
              st       <= S_ERR;
            end
          end else if (timer == TW'(SIG_TIMEOUT - 1)) begin
            err_code <= 3'd5;
            st       <= S_ERR;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  assert_mosi_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> $stable(spi_mosi));

  assert_strobe_len_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_strobe |-> !len_bad && !magic_bad && !id_bad);

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_strobe |=> !cfg_strobe);

  assert_final_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ok || err) |=> $stable(ok) && $stable(err) && $stable(err_code) && spi_cs_n && !cfg_strobe);

endmodule

// File: tb/cfg_loader_tb_top.sv
module cfg_loader_tb_top;

  localparam int HDR     = 32'h2A200;
  localparam int STRM    = 32'h2A400;
  localparam int FLASH   = 32'h100000;
  localparam int TMO     = 1000;
  localparam logic [31:0]  GOOD_MAGIC = 32'h11223344;
  localparam logic [127:0] GOOD_ID    = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;
  localparam logic [15:0]  GOOD_SIG   = 16'hC0DE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_cs_n, spi_sclk, spi_mosi;
  logic spi_miso = 1'b0;
  logic [7:0] cfg_data;
  logic cfg_strobe;
  logic tgt_done = 1'b0;
  logic [15:0] tgt_sig = '0;
  logic busy, ok, err;
  logic [2:0] err_code;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  cfg_loader dut_i (
    .clk(clk), .rst_n(rst_n),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .cfg_data(cfg_data), .cfg_strobe(cfg_strobe),
    .tgt_done(tgt_done), .tgt_sig(tgt_sig),
    .busy(busy), .ok(ok), .err(err), .err_code(err_code)
  );

  logic [31:0]  f_magic;
  logic [127:0] f_id;
  logic [31:0]  f_len;
  int fcnt, fbit, txn;
  logic [31:0] fin;
  logic [23:0] faddr;
  logic [7:0]  cmd0, cmd1;
  logic [23:0] addr0, addr1;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7) ^ (a >> 8));
  endfunction

  function automatic logic [7:0] flash_byte(input int a);
    if (a >= HDR && a < HDR + 4)        return f_magic[8*(a-HDR) +: 8];
    else if (a >= HDR + 4 && a < HDR + 20)  return f_id[8*(a-HDR-4) +: 8];
    else if (a >= HDR + 20 && a < HDR + 24) return f_len[8*(a-HDR-20) +: 8];
    else if (a >= STRM && a < FLASH)   return pat(a);
    else                                return 8'hFF;
  endfunction

  always @(negedge spi_cs_n) begin
    fcnt = 0;
    fbit = 0;
  end

  always @(posedge spi_sclk) begin
    if (!spi_cs_n && fcnt < 32) begin
      fin = {fin[30:0], spi_mosi};
      fcnt = fcnt + 1;
      if (fcnt == 32) begin
        faddr = fin[23:0];
        if (txn == 0) begin cmd0 = fin[31:24]; addr0 = fin[23:0]; end
        if (txn == 1) begin cmd1 = fin[31:24]; addr1 = fin[23:0]; end
        txn = txn + 1;
      end
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n && fcnt >= 32) begin
      spi_miso = flash_byte(int'(faddr))[7 - fbit];
      fbit = fbit + 1;
      if (fbit == 8) begin
        fbit = 0;
        faddr = faddr + 24'd1;
      end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired actual=%0d expected=<200000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic restart(input logic [31:0] m, input logic [127:0] id, input logic [31:0] len);
    rst_n = 1'b0;
    tgt_done = 1'b0;
    f_magic = m;
    f_id = id;
    f_len = len;
    txn = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic stream(input int n, output int k, output int bad);
    k = 0;
    bad = 0;
    for (int i = 0; i < 1000 + n * 20; i++) begin
      @(negedge clk);
      if (cfg_strobe) begin
        if (cfg_data !== pat(STRM + k)) bad++;
        k++;
        if (k == n) break;
      end
      if (!busy) break;
    end
  endtask

  task automatic wait_end(output int strobes);
    strobes = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (cfg_strobe) strobes++;
      if (!busy) break;
    end
  endtask

  task automatic send_sig(input logic [15:0] s);
    repeat (5) @(negedge clk);
    tgt_sig = s;
    tgt_done = 1'b1;
    repeat (2) @(negedge clk);
    tgt_done = 1'b0;
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 cs_n in reset", spi_cs_n, 1);
    chk("R1 sclk in reset", spi_sclk, 0);
    chk("R1 strobe in reset", cfg_strobe, 0);
    chk("R1 status in reset", {busy, ok, err}, 3'b100);
  endtask

  task automatic t_good(input int n);
    int k, bad, extra;
    restart(GOOD_MAGIC, GOOD_ID, n);
    stream(n, k, bad);
    chk("R6 strobe count", k, n);
    chk("R6 stream data errors", bad, 0);
    chk("R6 select released after last byte", spi_cs_n, 1);
    chk("R2 header command", cmd0, 8'h03);
    chk("R2 header address", addr0, 24'h2A200);
    chk("R6 stream command", cmd1, 8'h03);
    chk("R6 stream address", addr1, 24'h2A400);
    send_sig(GOOD_SIG);
    chk("R7 ok after matching signature", {ok, err, err_code}, 5'b10000);
    extra = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (cfg_strobe) extra++;
      if (i == 20) begin tgt_sig = 16'h1234; tgt_done = 1'b1; end
      if (i == 25) tgt_done = 1'b0;
    end
    chk("R10 ok held after late done", {ok, err, err_code, spi_cs_n}, 6'b100001);
    chk("R10 no strobe after ok", extra, 0);
    chk("R2 two transactions", txn, 2);
  endtask

  task automatic t_hdr_err(input string req, input logic [31:0] m, input logic [127:0] id,
                           input logic [31:0] len, input logic [2:0] code);
    int s;
    restart(m, id, len);
    wait_end(s);
    chk(req, {err, err_code}, {1'b1, code});
    chk({req, " no strobe"}, s, 0);
  endtask

  task automatic t_max_len();
    int k, bad;
    restart(GOOD_MAGIC, GOOD_ID, FLASH - STRM);
    stream(1, k, bad);
    chk("R5 length to end of flash accepted", {k, bad}, {32'd1, 32'd0});
    chk("R5 no error on max length", {busy, err}, 2'b10);
  endtask

  task automatic t_sig_bad();
    int k, bad;
    restart(GOOD_MAGIC, GOOD_ID, 6);
    stream(6, k, bad);
    send_sig(16'hC0DF);
    chk("R8 wrong signature", {err, err_code}, 4'b1100);
    repeat (20) @(negedge clk);
    chk("R10 error held", {err, err_code, spi_cs_n, cfg_strobe}, 6'b110010);
  endtask

  task automatic t_timeout();
    int k, bad;
    restart(GOOD_MAGIC, GOOD_ID, 3);
    stream(3, k, bad);
    chk("R9 stream before timeout", k, 3);
    repeat (TMO - 1) @(negedge clk);
    chk("R9 no error one cycle early", err, 0);
    @(negedge clk);
    chk("R9 timeout error", {err, err_code}, 4'b1101);
  endtask

  initial begin
    f_magic = GOOD_MAGIC; f_id = GOOD_ID; f_len = 0;
    txn = 0; fcnt = 0; fbit = 0; fin = 0; faddr = 0;
    cmd0 = 0; cmd1 = 0; addr0 = 0; addr1 = 0;
    t_reset_state();
    t_good(20);
    t_good(32'h103);
    t_hdr_err("R3 bad magic", 32'h11223345, GOOD_ID, 8, 3'd1);
    t_hdr_err("R4 bad last identity byte", GOOD_MAGIC, GOOD_ID ^ {8'h01, 120'd0}, 8, 3'd2);
    t_hdr_err("R3 magic wins over identity", 32'h01223344, ~GOOD_ID, 8, 3'd1);
    t_hdr_err("R5 zero length", GOOD_MAGIC, GOOD_ID, 0, 3'd3);
    t_hdr_err("R5 length past end", GOOD_MAGIC, GOOD_ID, FLASH - STRM + 1, 3'd3);
    t_max_len();
    t_good(1);
    t_sig_bad();
    t_timeout();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule